// File: doc/BRIEF.md
# Two-Wire Register Slave with Strap Address and Identification Bank

This block connects a register file to a two-wire serial bus of the SMBus/I2C kind. It runs on a fast system clock and oversamples the bus clock and data lines through short synchronizers. It detects start and stop conditions and answers to one 7-bit address. That address is made of five fixed high bits (`00111`) and two strap inputs as its low bits. The only output to the bus is an enable that pulls the data line low, so the open-drain wiring stays outside the block.

In a write transaction, the first byte after the address sets an internal register pointer. Each later byte is written through a one-cycle strobe on the register-file port, and the pointer then advances. To read, a master usually writes the pointer, issues a repeated start and readdresses for reading. The slave then shifts register bytes out MSB first and advances the pointer after every byte. Four addresses, `0xF4`..`0xF7`, are served from a hardwired identification bank and cannot be written.

Top module: `smb_slave_regif`

## Requirements
- R1: After reset the data-line pull enable is low and no register write strobe is issued.
- R2: An address byte whose upper seven bits equal `0,0,1,1,1,strap[1],strap[0]` (MSB first) is acknowledged by pulling the data line low for the ninth clock pulse. Bit 0 is the direction (0 write, 1 read).
- R3: A non-matching address is not acknowledged, and the slave neither drives the line nor writes until the next start condition.
- R4: In a write, the first byte after the address loads the pointer without a write. Each further byte is acknowledged and presented on the register port with a one-cycle strobe, at the current pointer value.
- R5: The pointer advances by one after every data byte, read or written, and wraps from `0xFF` to `0x00`.
- R6: In a read, the byte at the pointer is shifted out MSB first, one bit per clock pulse. A master acknowledge makes the slave continue with the next byte.
- R7: Reads at `0xF4`, `0xF5`, `0xF6` and `0xF7` return `0x41`, `0x02`, `0x00` and `0x00`, whatever the register file holds.
- R8: Writes to `0xF4`..`0xF7` are acknowledged, issue no strobe, and leave the readback values unchanged.
- R9: When the master leaves the ninth bit of a read byte high (no acknowledge), the slave releases the line and does not drive it again before a new start.
- R10: A repeated start restarts address reception and keeps the pointer, so a pointer write followed by a repeated-start read returns data from that pointer.
- R11: A stop condition ends the transaction. Clock pulses that follow it without a start are neither acknowledged nor written.
- R12: The pull enable changes only while the synchronized bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_pull_o | output | 1 | High to pull the data line low |
| strap_i | input | 2 | Low two bits of the slave address |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | 8 | Register pointer, used as address for reads and writes |
| reg_wdata_o | output | 8 | Write data, valid with the strobe |
| reg_rdata_i | input | 8 | Register-file read data for `reg_addr_o` |

## Verification
The bus is driven a quarter-period of six system clocks at a time. Every response of the block comes from a bus-clock edge seen through the two synchronizer flops and one compare flop. The pull enable therefore moves three to four system cycles after a bus-clock fall. The bench always reads the wired line at the middle of the bus-clock high phase, well after that delay and before the next fall. Write strobes arrive about three cycles after the eighth rising edge of a byte. Their effect is checked later through a readback transaction rather than at a fixed cycle, and a monitor counts strobes aimed at the identification addresses.

// File: rtl/smb_regif_pkg.sv
package smb_regif_pkg;

  // Byte-level phases of the serial link.
  typedef enum logic [2:0] {
    ST_IDLE,    // not addressed; wait for a start
    ST_RX,      // shifting in a byte from the master
    ST_RX_ACK,  // acknowledging a received byte
    ST_TX,      // shifting out a register byte
    ST_TX_ACK   // sampling the master acknowledge
  } smb_state_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    if (STAGES > 1) chain_d = {chain_q[STAGES-2:0], line_i};
    else            chain_d = line_i;
    prev_d = chain_q[STAGES-1];
  end

  // Idle bus level is high, so reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/smb_id_bank.sv
module smb_id_bank #(
  parameter logic [7:0] ID_BASE = 8'hF4,
  parameter logic [7:0] ID_V0   = 8'h41,
  parameter logic [7:0] ID_V1   = 8'h02,
  parameter logic [7:0] ID_V2   = 8'h00,
  parameter logic [7:0] ID_V3   = 8'h00
) (
  input  logic [7:0] addr_i,
  output logic       hit_o,
  output logic [7:0] data_o
);

  always_comb begin
    hit_o = (addr_i[7:2] == ID_BASE[7:2]);
    unique case (addr_i[1:0])
      2'd0:    data_o = ID_V0;
      2'd1:    data_o = ID_V1;
      2'd2:    data_o = ID_V2;
      default: data_o = ID_V3;
    endcase
  end

endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_regif_pkg::*;
#(
  parameter int unsigned STRAP_W    = 2,
  parameter logic [6-STRAP_W:0] ADDR_FIXED = 5'b00111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_lvl_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               sda_lvl_i,
  input  logic               sda_rise_i,
  input  logic               sda_fall_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  input  logic               protect_i,
  output logic               pull_o,
  output logic [BYTE_W-1:0]  ptr_o,
  output logic               wr_o,
  output logic [BYTE_W-1:0]  wdata_o,
  output smb_state_e         state_o
);

  localparam int unsigned CNT_W    = 4;
  localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W);

  smb_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic              rw_q, rw_d;
  logic              cmd_q, cmd_d;
  logic              addr_q, addr_d;
  logic              pull_q, pull_d;
  logic              mack_q, mack_d;
  logic              wr_q, wr_d;
  logic              inc_q, inc_d;

  logic              start_det, stop_det;
  logic [BYTE_W-1:0] rx_byte;

  assign start_det = sda_fall_i & scl_lvl_i;
  assign stop_det  = sda_rise_i & scl_lvl_i;
  assign rx_byte   = {sh_q[BYTE_W-2:0], sda_lvl_i};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    wdata_d = wdata_q;
    rw_d    = rw_q;
    cmd_d   = cmd_q;
    addr_d  = addr_q;
    pull_d  = pull_q;
    mack_d  = mack_q;
    wr_d    = 1'b0;
    inc_d   = 1'b0;

    if (inc_q) ptr_d = ptr_q + 1'b1;

    if (start_det) begin
      state_d = ST_RX;
      cnt_d   = '0;
      addr_d  = 1'b1;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            sh_d  = rx_byte;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_RX) begin
              cnt_d   = '0;
              state_d = ST_RX_ACK;
              if (addr_q) begin
                addr_d = 1'b0;
                if (rx_byte[BYTE_W-1:1] == {ADDR_FIXED, strap_i}) begin
                  rw_d  = rx_byte[0];
                  cmd_d = ~rx_byte[0];
                end else begin
                  state_d = ST_IDLE;
                end
              end else if (cmd_q) begin
                cmd_d = 1'b0;
                ptr_d = rx_byte;
              end else begin
                inc_d = 1'b1;
                if (!protect_i) begin
                  wr_d    = 1'b1;
                  wdata_d = rx_byte;
                end
              end
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) begin
            if (!pull_q) begin
              pull_d = 1'b1;
            end else begin
              pull_d = 1'b0;
              cnt_d  = '0;
              if (rw_q) begin
                tx_d    = rd_data_i;
                pull_d  = ~rd_data_i[BYTE_W-1];
                state_d = ST_TX;
              end else begin
                state_d = ST_RX;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall_i) begin
            if (cnt_q == LAST_TX) begin
              pull_d  = 1'b0;
              inc_d   = 1'b1;
              state_d = ST_TX_ACK;
            end else begin
              pull_d = ~tx_q[3'd7 - cnt_q[2:0]];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            mack_d = ~sda_lvl_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              tx_d    = rd_data_i;
              pull_d  = ~rd_data_i[BYTE_W-1];
              cnt_d   = '0;
              state_d = ST_TX;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
          pull_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      wdata_q <= '0;
      rw_q    <= 1'b0;
      cmd_q   <= 1'b0;
      addr_q  <= 1'b0;
      pull_q  <= 1'b0;
      mack_q  <= 1'b0;
      wr_q    <= 1'b0;
      inc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      wdata_q <= wdata_d;
      rw_q    <= rw_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      pull_q  <= pull_d;
      mack_q  <= mack_d;
      wr_q    <= wr_d;
      inc_q   <= inc_d;
    end
  end

  assign pull_o  = pull_q;
  assign ptr_o   = ptr_q;
  assign wr_o    = wr_q;
  assign wdata_o = wdata_q;
  assign state_o = state_q;

endmodule

// File: rtl/smb_slave_regif.sv
module smb_slave_regif
  import smb_regif_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STRAP_W     = 2,
  parameter logic [6-STRAP_W:0] ADDR_FIXED = 5'b00111,
  parameter logic [7:0]  ID_BASE     = 8'hF4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               reg_wr_o,
  output logic [7:0]         reg_addr_o,
  output logic [7:0]         reg_wdata_o,
  input  logic [7:0]         reg_rdata_i
);

  localparam int unsigned N_LINES = 2;
  localparam int unsigned IDX_SCL = 0;
  localparam int unsigned IDX_SDA = 1;

  logic [N_LINES-1:0] line_raw, line_lvl, line_rise, line_fall;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_raw[g]),
      .lvl_o  (line_lvl[g]),
      .rise_o (line_rise[g]),
      .fall_o (line_fall[g])
    );
  end

  logic       scl_lvl, sda_rise;
  logic       id_hit;
  logic [7:0] id_data, rd_mux;
  logic [7:0] ptr;
  smb_state_e link_state;

  assign scl_lvl  = line_lvl[IDX_SCL];
  assign sda_rise = line_rise[IDX_SDA];

  smb_id_bank #(.ID_BASE(ID_BASE)) id_i (
    .addr_i (ptr),
    .hit_o  (id_hit),
    .data_o (id_data)
  );

  assign rd_mux = id_hit ? id_data : reg_rdata_i;

  smb_link #(.STRAP_W(STRAP_W), .ADDR_FIXED(ADDR_FIXED)) link_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl_i  (scl_lvl),
    .scl_rise_i (line_rise[IDX_SCL]),
    .scl_fall_i (line_fall[IDX_SCL]),
    .sda_lvl_i  (line_lvl[IDX_SDA]),
    .sda_rise_i (sda_rise),
    .sda_fall_i (line_fall[IDX_SDA]),
    .strap_i    (strap_i),
    .rd_data_i  (rd_mux),
    .protect_i  (id_hit),
    .pull_o     (sda_pull_o),
    .ptr_o      (ptr),
    .wr_o       (reg_wr_o),
    .wdata_o    (reg_wdata_o),
    .state_o    (link_state)
  );

  assign reg_addr_o = ptr;

endmodule

// File: rtl/smb_slave_regif_chk.sv
module smb_slave_regif_chk
  import smb_regif_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_rise,
  input logic       sda_pull_o,
  input logic       reg_wr_o,
  input logic [7:0] reg_addr_o,
  input smb_state_e state
);

  assert_quiet_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull_o);

  assert_pull_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_lvl);

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> (reg_addr_o == $past(reg_addr_o) + 8'd1));

  assert_no_id_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> (reg_addr_o[7:2] != 6'h3D));

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_rise && scl_lvl) |=> (!sda_pull_o && state == ST_IDLE));

endmodule

bind smb_slave_regif smb_slave_regif_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_lvl    (scl_lvl),
  .sda_rise   (sda_rise),
  .sda_pull_o (sda_pull_o),
  .reg_wr_o   (reg_wr_o),
  .reg_addr_o (reg_addr_o),
  .state      (link_state)
);

// File: tb/smb_slave_regif_tb.sv
module smb_slave_regif_tb_top;

  localparam int Q = 6;

  logic       clk, rst_n;
  logic       scl_m, sda_m;
  logic       sda_pull, sda_line;
  logic [1:0] strap;
  logic       reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;

  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  int         n_checks, n_errors, wr_cnt, id_wr_cnt, cyc;

  assign sda_line = sda_m & ~sda_pull;

  smb_slave_regif dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_pull_o  (sda_pull),
    .strap_i     (strap),
    .reg_wr_o    (reg_wr),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_rdata_i (reg_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Register file model attached to the port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      wr_cnt    <= 0;
      id_wr_cnt <= 0;
    end else if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt        <= wr_cnt + 1;
      if (reg_addr >= 8'hF4 && reg_addr <= 8'hF7) id_wr_cnt <= id_wr_cnt + 1;
    end
  end
  assign reg_rdata = mem[reg_addr];

  function automatic logic is_id(input logic [7:0] a);
    return a >= 8'hF4 && a <= 8'hF7;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'hF4:   return 8'h41;
      8'hF5:   return 8'h02;
      8'hF6:   return 8'h00;
      8'hF7:   return 8'h00;
      default: return exp_mem[a];
    endcase
  endfunction

  function automatic logic [7:0] addr_byte(input logic [1:0] s, input logic rd);
    return {5'b00111, s, rd};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    sda_m = b;  wait_q();
    scl_m = 1'b1; wait_q();
    seen = sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_low);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack_low = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, s);
      d = {d[6:0], s};
    end
    bus_bit(~mack, s);
  endtask

  // Pointer write followed by data bytes.
  task automatic do_write(input logic [7:0] ptr, input int n, input logic [7:0] d0,
                          input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3);
    logic ack;
    logic [7:0] a, d;
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    check("R2 address ack (write)", ack, 1);
    send_byte(ptr, ack);
    check("R4 pointer byte ack", ack, 1);
    a = ptr;
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : (i == 2) ? d2 : d3;
      send_byte(d, ack);
      check(is_id(a) ? "R8 id write ack" : "R4 data ack", ack, 1);
      if (!is_id(a)) exp_mem[a] = d;
      a = a + 8'd1;
    end
    bus_stop();
  endtask

  // Pointer write, repeated start, read n bytes and compare.
  task automatic do_read(input logic [7:0] ptr, input int n, input string req);
    logic ack;
    logic [7:0] a, d;
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    check("R2 address ack", ack, 1);
    send_byte(ptr, ack);
    check("R4 pointer ack", ack, 1);
    bus_restart();
    send_byte(addr_byte(strap, 1'b1), ack);
    check("R10 readdress ack", ack, 1);
    a = ptr;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      check(req, d, exp_read(a));
      a = a + 8'd1;
    end
    bus_stop();
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
      end
    end
  end

  initial begin
    logic ack, s;
    logic [7:0] d;
    int base_wr;
    n_checks = 0;
    n_errors = 0;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    scl_m = 1'b1; sda_m = 1'b1; strap = 2'b10;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 pull low in reset", sda_pull, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 pull low after reset", sda_pull, 0);
    check("R1 no strobe after reset", reg_wr, 0);

    // Basic write and repeated-start read (R4, R6, R10).
    do_write(8'h10, 3, 8'hA5, 8'h3C, 8'hF0, 8'h00);
    do_read(8'h10, 3, "R6 read data");
    do_read(8'h11, 1, "R10 read at kept pointer");

    // Wrong address: strap gives 10, master sends 01 (R3).
    base_wr = wr_cnt;
    bus_start();
    send_byte(addr_byte(2'b01, 1'b0), ack);
    check("R3 no ack on mismatch", ack, 0);
    send_byte(8'h20, ack);
    check("R3 no ack after mismatch", ack, 0);
    send_byte(8'h99, ack);
    check("R3 no ack on data", ack, 0);
    bus_stop();
    check("R3 no strobe", wr_cnt - base_wr, 0);
    do_read(8'h20, 1, "R3 register untouched");

    // Identification bank reads and protected writes (R7, R8).
    do_read(8'hF4, 4, "R7 id value");
    base_wr = wr_cnt;
    do_write(8'hF4, 4, 8'hFF, 8'hEE, 8'hDD, 8'hCC);
    check("R8 no strobe on id writes", wr_cnt - base_wr, 0);
    check("R8 no id strobe total", id_wr_cnt, 0);
    do_read(8'hF3, 6, "R8 id readback unchanged");

    // Pointer wrap (R5).
    do_write(8'hFE, 3, 8'h11, 8'h22, 8'h33, 8'h00);
    do_read(8'hFE, 3, "R5 wrap readback");

    // Master NACK then one extra pulse (R9).
    bus_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    check("R2 address ack (read)", ack, 1);
    recv_byte(1'b0, d);
    check("R9 data before nack", d, exp_read(8'h01));
    bus_bit(1'b0, s);
    check("R9 line released after nack", s, 0);
    sda_m = 1'b1;
    bus_bit(1'b1, s);
    check("R9 line high after nack", s, 1);
    check("R9 pull off", sda_pull, 0);
    bus_stop();

    // Stop ends the transaction (R11).
    base_wr = wr_cnt;
    bus_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    send_byte(8'h40, ack);
    send_byte(8'h5A, ack);
    check("R11 data ack", ack, 1);
    exp_mem[8'h40] = 8'h5A;
    bus_stop();
    scl_m = 1'b0; wait_q();
    send_byte(8'h77, ack);
    check("R11 no ack after stop", ack, 0);
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    check("R11 single strobe", wr_cnt - base_wr, 1);
    do_read(8'h40, 2, "R11 readback");

    // Random transactions, fixed seed.
    void'($urandom(32'd7331));
    for (int t = 0; t < 16; t++) begin
      logic [7:0] p;
      int n;
      strap = 2'($urandom);
      p = 8'($urandom);
      n = 1 + ($urandom % 4);
      do_write(p, n, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      do_read(p, n, "R6 random readback");
    end
    check("R8 no id strobe at end", id_wr_cnt, 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule